// File: doc/BRIEF.md
# Charge-Time Capacitance Measurement Sequencer

This block runs one capacitance measurement at a time by timing how long a capacitor takes to charge from empty up to a comparator threshold. On a start request it turns on the external current source. It then holds the open-drain discharge switch for a fixed number of clocks so the capacitor starts from zero volts. When it releases the switch, a ramp counter starts. This counter advances once per slow tick made by dividing the system clock. When the external comparator trips, the counter value is captured and a one-cycle done pulse is raised.

The release of the discharge switch and the enable of the ramp counter come from one register bit, so timing starts on the same clock as the ramp. The comparator output is asynchronous and passes through a two-stage synchronizer. Each count stands for a fixed charge time, 2 us at the default divide ratio. With the expected source current and threshold, one count is about 10 pF. The block therefore also reports the count multiplied by a picofarad-per-step constant.

Top module: `cap_charge_timer`

## Requirements
- R1: After reset the current source is off (`src_en_o`=0), the discharge switch is on (`dis_o`=1), and `count_o`, `count_pf_o`, `done_o`, `ovf_o` and `err_o` are all 0.
- R2: A start request seen in idle turns on `src_en_o` one clock later while `dis_o` stays 1. The switch is released (`dis_o`=0) after `src_en_o` and `dis_o` have both been 1 for exactly DISCH_CLKS+1 clocks, where DISCH_CLKS is raised to 16 if set lower.
- R3: If the comparator input rises j clocks after the first clock with `dis_o`=0, `count_o` reports floor((j+2)/TICK_DIV). This covers the two synchronizer clocks and a count that advances once every TICK_DIV clocks from release.
- R4: `done_o` is 1 for exactly one clock, 3 clocks after the comparator input rises. `count_o`, `count_pf_o`, `ovf_o` and `err_o` are valid in that clock and hold until the next start.
- R5: `count_pf_o` equals `count_o` × PF_PER_STEP (10 by default).
- R6: If the count reaches 2^CNT_W−1 (255) and no comparator rise arrives in the clock it is reached, the measurement ends 255·TICK_DIV+1 clocks after release with `ovf_o`=1, `count_o`=255 and a done pulse. A comparator rise detected in that same clock takes priority and is reported as a normal count of 255 with `ovf_o`=0.
- R7: If the synchronized comparator is already high in the first ramp clock, the measurement ends one clock later with `count_o`=0, `err_o`=1 and a done pulse.
- R8: A start request during a measurement is ignored. The running result is unaffected and no second measurement follows it.
- R9: In the clock of the done pulse `src_en_o` is 0 and `dis_o` is 1 again. `ovf_o` and `err_o` clear when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled in idle only |
| cmp_i | input | 1 | Asynchronous comparator output, high when the threshold is crossed |
| src_en_o | output | 1 | Current-source enable |
| dis_o | output | 1 | Discharge switch drive, 1 pulls the capacitor low |
| count_o | output | CNT_W | Captured ramp count |
| count_pf_o | output | PF_W | Captured count times PF_PER_STEP |
| done_o | output | 1 | One-clock end-of-measurement pulse |
| ovf_o | output | 1 | Count saturated without a comparator trip |
| err_o | output | 1 | Comparator was high at release |

## Verification
Each check is timed from the first negative edge at which `dis_o` reads 0. The bench then counts the clocks up to the edge where it drives the comparator. The result is due exactly three clocks after that: two synchronizer stages and one capture register. The checks confirm that `done_o` is low in the two clocks before and high in the third. An overflow run is due 255·TICK_DIV+1 clocks after release, and an early-comparator run one clock after release. The discharge length is measured by counting clocks with both the source enable and the switch active.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SRC   = 2'd1,
    ST_DISCH = 2'd2,
    ST_RAMP  = 2'd3
  } cct_state_t;
endpackage

// File: rtl/cct_tick_div.sv
module cct_tick_div #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] phase_q;

  // phase restarts whenever the ramp is not running
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase_q <= '0;
    end else if (phase_q == LAST) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign tick = run && (phase_q == LAST);
endmodule

// File: rtl/cct_sync.sv
module cct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cct_ramp_counter.sv
module cct_ramp_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         at_max
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (tick && !at_max) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt    = cnt_q;
  assign at_max = &cnt_q;
endmodule

// File: rtl/cap_charge_timer.sv
module cap_charge_timer
  import cct_pkg::*;
#(
  parameter int TICK_DIV    = 100,
  parameter int DISCH_CLKS  = 32,
  parameter int CNT_W       = 8,
  parameter int PF_PER_STEP = 10,
  parameter int SYNC_STAGES = 2,
  localparam int PF_W = CNT_W + $clog2(PF_PER_STEP + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             src_en_o,
  output logic             dis_o,
  output logic [CNT_W-1:0] count_o,
  output logic [PF_W-1:0]  count_pf_o,
  output logic             done_o,
  output logic             ovf_o,
  output logic             err_o
);
  localparam int DISCH_EFF = (DISCH_CLKS < 16) ? 16 : DISCH_CLKS;
  localparam int DT_W      = $clog2(DISCH_EFF + 1);
  localparam logic [DT_W-1:0] DT_LAST = DT_W'(DISCH_EFF - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  cct_state_t       state_q;
  logic             src_q;
  logic             ramp_q;    // one bit: releases the switch and enables counting
  logic             first_q;
  logic [DT_W-1:0]  dtim_q;
  logic             cmp_s;
  logic             cmp_prev_q;
  logic             tick;
  logic [CNT_W-1:0] ramp_cnt;
  logic             ramp_max;
  logic [CNT_W-1:0] cnt_q;
  logic [PF_W-1:0]  pf_q;
  logic             done_q;
  logic             ovf_q;
  logic             err_q;

  logic             early;
  logic             trip;

  cct_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (cmp_i),
    .q   (cmp_s)
  );

  cct_tick_div #(.DIV(TICK_DIV)) div_i (
    .clk  (clk),
    .rst  (rst),
    .run  (ramp_q),
    .tick (tick)
  );

  cct_ramp_counter #(.W(CNT_W)) ctr_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (!ramp_q),
    .tick   (tick),
    .cnt    (ramp_cnt),
    .at_max (ramp_max)
  );

  always_ff @(posedge clk) begin
    if (rst) cmp_prev_q <= 1'b0;
    else     cmp_prev_q <= cmp_s;
  end

  assign early = ramp_q && first_q && cmp_s;
  assign trip  = ramp_q && !first_q && cmp_s && !cmp_prev_q;

  function automatic logic [PF_W-1:0] to_pf(input logic [CNT_W-1:0] c);
    return PF_W'(c) * PF_W'(PF_PER_STEP);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      src_q   <= 1'b0;
      ramp_q  <= 1'b0;
      first_q <= 1'b0;
      dtim_q  <= '0;
      cnt_q   <= '0;
      pf_q    <= '0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SRC;
            src_q   <= 1'b1;
            ovf_q   <= 1'b0;
            err_q   <= 1'b0;
          end
        end
        ST_SRC: begin
          state_q <= ST_DISCH;
          dtim_q  <= '0;
        end
        ST_DISCH: begin
          dtim_q <= dtim_q + 1'b1;
          if (dtim_q == DT_LAST) begin
            state_q <= ST_RAMP;
            ramp_q  <= 1'b1;
            first_q <= 1'b1;
          end
        end
        ST_RAMP: begin
          first_q <= 1'b0;
          if (early || trip || ramp_max) begin
            state_q <= ST_IDLE;
            ramp_q  <= 1'b0;
            src_q   <= 1'b0;
            done_q  <= 1'b1;
            if (early) begin
              cnt_q <= '0;
              pf_q  <= '0;
              err_q <= 1'b1;
            end else if (trip) begin
              cnt_q <= ramp_cnt;
              pf_q  <= to_pf(ramp_cnt);
            end else begin
              cnt_q <= CNT_MAX;
              pf_q  <= to_pf(CNT_MAX);
              ovf_q <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign src_en_o   = src_q;
  assign dis_o      = !ramp_q;
  assign count_o    = cnt_q;
  assign count_pf_o = pf_q;
  assign done_o     = done_q;
  assign ovf_o      = ovf_q;
  assign err_o      = err_q;
endmodule

// File: rtl/cap_charge_timer_chk.sv
module cap_charge_timer_chk #(
  parameter int CNT_W       = 8,
  parameter int PF_PER_STEP = 10,
  parameter int PF_W        = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             src_en_o,
  input logic             dis_o,
  input logic [CNT_W-1:0] count_o,
  input logic [PF_W-1:0]  count_pf_o,
  input logic             done_o,
  input logic             ovf_o,
  input logic             err_o
);
  assert_release_needs_source_R2: assert property (@(posedge clk) disable iff (rst)
    !dis_o |-> src_en_o);

  assert_release_after_source_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(dis_o) |-> $past(src_en_o));

  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_result_held_R4: assert property (@(posedge clk) disable iff (rst)
    (!done_o && !$rose(src_en_o)) |-> $stable(count_o));

  assert_pf_scaled_R5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (count_pf_o == PF_W'(count_o) * PF_W'(PF_PER_STEP)));

  assert_ovf_count_R6: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (&count_o));

  assert_err_count_R7: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (count_o == '0) && !ovf_o);

  assert_parked_at_done_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (dis_o && !src_en_o));
endmodule

bind cap_charge_timer cap_charge_timer_chk #(
  .CNT_W(CNT_W), .PF_PER_STEP(PF_PER_STEP), .PF_W(PF_W)
) chk_i (
  .clk(clk), .rst(rst), .src_en_o(src_en_o), .dis_o(dis_o),
  .count_o(count_o), .count_pf_o(count_pf_o), .done_o(done_o),
  .ovf_o(ovf_o), .err_o(err_o)
);

// File: tb/cap_charge_timer_tb_top.sv
module cap_charge_timer_tb_top;
  localparam int TDIV   = 4;
  localparam int DCLK   = 16;
  localparam int CW     = 8;
  localparam int PFS    = 10;
  localparam int PW     = CW + $clog2(PFS + 1);
  localparam int OVF_AT = 255 * TDIV + 1;

  localparam int NV = 8;
  localparam int VEC_D   [NV] = '{0, 1, 2, 5, 13, 40, 200, 1017};
  localparam int VEC_CNT [NV] = '{0, 0, 1, 1, 3, 10, 50, 254};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic cmp_i = 1'b0;
  logic src_en_o, dis_o, done_o, ovf_o, err_o;
  logic [CW-1:0] count_o;
  logic [PW-1:0] count_pf_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cap_charge_timer #(
    .TICK_DIV(TDIV), .DISCH_CLKS(DCLK), .CNT_W(CW), .PF_PER_STEP(PFS)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .cmp_i(cmp_i),
    .src_en_o(src_en_o), .dis_o(dis_o), .count_o(count_o),
    .count_pf_o(count_pf_o), .done_o(done_o), .ovf_o(ovf_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // d < 0: comparator never rises. mid >= 0: extra start pulse in the ramp.
  task automatic measure(input int d, input int exp_cnt, input bit exp_ovf,
                         input bit exp_err, input int mid);
    int held;
    int guard;
    int due;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(ovf_o == 1'b0 && err_o == 1'b0, "R9 flags cleared", int'({ovf_o, err_o}), 0);
    chk(src_en_o == 1'b1 && dis_o == 1'b1, "R2 source on first", int'({src_en_o, dis_o}), 3);
    held = 0;
    guard = 0;
    while (dis_o && guard < 200) begin
      if (src_en_o) held++;
      guard++;
      @(negedge clk);
    end
    chk(held == DCLK + 1, "R2 discharge length", held, DCLK + 1);
    if (exp_err) due = 1;
    else if (exp_ovf && (d < 0 || d + 3 > OVF_AT)) due = OVF_AT;
    else due = d + 3;
    if (d == 0) cmp_i = 1'b1;
    for (int k = 1; k <= due; k++) begin
      @(negedge clk);
      if (k == d) cmp_i = 1'b1;
      if (mid >= 0 && k == mid) start_i = 1'b1;
      if (mid >= 0 && k == mid + 1) start_i = 1'b0;
      if (k == due - 1) chk(done_o == 1'b0, "R4 done not early", done_o, 0);
    end
    chk(done_o == 1'b1, "R4 done on time", done_o, 1);
    chk(count_o == CW'(exp_cnt), "R3 count", count_o, exp_cnt);
    chk(count_pf_o == PW'(exp_cnt * PFS), "R5 scaled count", count_pf_o, exp_cnt * PFS);
    chk(ovf_o == exp_ovf, "R6 overflow flag", ovf_o, exp_ovf);
    chk(err_o == exp_err, "R7 error flag", err_o, exp_err);
    chk(dis_o == 1'b1 && src_en_o == 1'b0, "R9 parked at done", int'({dis_o, src_en_o}), 2);
    @(negedge clk);
    chk(done_o == 1'b0, "R4 done one clock", done_o, 0);
    cmp_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(src_en_o == 1'b0 && count_o == CW'(exp_cnt), "R8 R4 idle and held",
        count_o, exp_cnt);
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(src_en_o == 0 && dis_o == 1 && done_o == 0, "R1 control outputs",
        int'({src_en_o, dis_o, done_o}), 2);
    chk(count_o == 0 && count_pf_o == 0 && ovf_o == 0 && err_o == 0, "R1 result outputs",
        int'(count_o), 0);

    // table of comparator delays and expected counts (R3)
    for (int i = 0; i < NV; i++) measure(VEC_D[i], VEC_CNT[i], 1'b0, 1'b0, -1);

    // R8: start pulse during the ramp is ignored
    measure(40, 10, 1'b0, 1'b0, 12);
    // R6: trip in the clock the count saturates wins over overflow
    measure(1018, 255, 1'b0, 1'b0, -1);
    // R6: trip one clock too late, overflow reported
    measure(1019, 255, 1'b1, 1'b0, -1);
    // R6: comparator never rises
    measure(-1, 255, 1'b1, 1'b0, -1);
    // R7: comparator already high at release
    cmp_i = 1'b1;
    measure(-1, 0, 1'b0, 1'b1, -1);
    // R9: flags from the error run clear on the next start
    measure(5, 1, 1'b0, 1'b0, -1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule